// File: doc/BRIEF.md
# Mode-Configurable 16-bit Multiplier

This block is a two-stage registered multiplier for two 16-bit operands. A three-bit mode input selects its shape and its width: one signed 16x16 multiply, one signed 8x8 multiply on the low bytes, or two independent signed 8x8 multiplies side by side, one per byte lane. The product is 32 bits wide.

The datapath holds four 9x9 signed sub-multipliers, one for each pairing of operand bytes. Each byte is widened to 9 bits in one of two ways. In the 16-bit shape the low bytes are zero-extended and the high bytes are sign-extended, so the four sub-products, shifted and summed, give the full signed product. In the byte shapes every byte is sign-extended. Sub-products that the selected shape does not need are held at zero.

The low mode bit selects the output width. When it is clear, the low half of each result lane is cleared, which gives a fixed-width result. A zero detector looks at the incoming operands. When the selected shape's result must be zero, it stops the input registers from loading and clears the output register.

Top module: `cfg_mult16`

## Requirements
- R1: While `rst` is high at a rising clock edge, `prod_q` becomes 0 at that edge.
- R2: Operands and mode that are present at rising edge k appear as their result on `prod_q` after rising edge k+1. The output holds its previous value after edge k.
- R3: With `mode_in[2:1]` = 2'b11 and `mode_in[0]` = 1, `prod_q` is the signed 32-bit product of `a_in` and `b_in`, both read as two's complement.
- R4: With `mode_in[2:1]` = 2'b10 and `mode_in[0]` = 1, `prod_q` is the signed product of `a_in[7:0]` and `b_in[7:0]`, sign-extended to 32 bits. The high bytes have no effect.
- R5: With `mode_in[2:1]` = 2'b00 and `mode_in[0]` = 1, `prod_q[31:16]` is the signed product of the high bytes and `prod_q[15:0]` is the signed product of the low bytes. The two lanes are independent.
- R6: With `mode_in[0]` = 0, the result of the selected shape is formed and then masked. In the 16-bit shape bits [15:0] are zero. In the single-byte shape bits [7:0] are zero. In the twin shape bits [7:0] and [23:16] are zero.
- R7: `mode_in[2:1]` = 2'b01 behaves exactly like 2'b11.
- R8: The unit shuts down when the selected shape's result must be zero. In the 16-bit shape this happens when either whole operand is 0. In the single-byte shape it happens when either low byte is 0. In the twin shape it happens when each lane has a zero byte. On shutdown the input registers keep their contents and `prod_q` is 0 after the second edge.
- R9: In the byte shapes, the sub-products that pair a high byte with a low byte are forced to zero. So are the high-times-high sub-product in the single-byte shape, and in the twin shape a cross-lane byte has no effect on either lane.
- R10: In the twin shape, a lane that has a zero byte yields 0 in its half while the other lane still gives its product. The unit is not shut down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| mode_in | input | 3 | [2:1] shape select, [0] full-width enable |
| prod_q | output | 32 | Registered product |

## Verification
Every result, including the cleared output after a shutdown, reaches `prod_q` after the second rising edge that follows the input change. The bench drives inputs on a falling edge, lets two rising edges pass and reads `prod_q` on the following falling edge. One directed test also reads the output after only one edge, to show that the old value is still held there. The reset check reads the output one falling edge after a reset edge.

// File: rtl/cfgmul_pkg.sv
package cfgmul_pkg;

    localparam int HALF_W = 8;
    localparam int WORD_W = 2 * HALF_W;
    localparam int PROD_W = 2 * WORD_W;
    localparam int EXT_W  = HALF_W + 1;
    localparam int SUB_W  = 2 * EXT_W;
    localparam int N_SUB  = 4;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        SHAPE_TWIN   = 2'b00,
        SHAPE_WIDE_R = 2'b01,
        SHAPE_BYTE   = 2'b10,
        SHAPE_WIDE   = 2'b11
    } shape_e;

    typedef struct packed {
        shape_e shape;
        logic   full;
    } mode_t;

    typedef struct packed {
        logic signed [EXT_W-1:0] x;
        logic signed [EXT_W-1:0] y;
        logic                    en;
    } sub_op_t;

    typedef struct packed {
        logic a_lz;
        logic a_hz;
        logic b_lz;
        logic b_hz;
        logic sign;
        logic shut;
    } zinfo_t;

    function automatic logic is_wide(shape_e s);
        return (s == SHAPE_WIDE) || (s == SHAPE_WIDE_R);
    endfunction

    function automatic logic signed [EXT_W-1:0] widen(logic [HALF_W-1:0] v, logic sext);
        return {sext & v[HALF_W-1], v};
    endfunction

endpackage

// File: rtl/cfgmul_sbg.sv
module cfgmul_sbg
    import cfgmul_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  shape_e            shape,
    output zinfo_t            info
);

    always_comb begin
        info.a_lz = (a[HALF_W-1:0] == '0);
        info.a_hz = (a[WORD_W-1:HALF_W] == '0);
        info.b_lz = (b[HALF_W-1:0] == '0);
        info.b_hz = (b[WORD_W-1:HALF_W] == '0);
        if (is_wide(shape)) begin
            info.shut = (info.a_lz & info.a_hz) | (info.b_lz & info.b_hz);
            info.sign = a[WORD_W-1] ^ b[WORD_W-1];
        end else if (shape == SHAPE_BYTE) begin
            info.shut = info.a_lz | info.b_lz;
            info.sign = a[HALF_W-1] ^ b[HALF_W-1];
        end else begin
            info.shut = (info.a_lz | info.b_lz) & (info.a_hz | info.b_hz);
            info.sign = (a[WORD_W-1] ^ b[WORD_W-1]) & ~(info.a_hz | info.b_hz);
        end
    end

endmodule

// File: rtl/cfgmul_sub.sv
module cfgmul_sub
    import cfgmul_pkg::*;
(
    input  sub_op_t                 op,
    output logic signed [SUB_W-1:0] p
);

    always_comb begin
        if (op.en) p = op.x * op.y;
        else       p = '0;
    end

endmodule

// File: rtl/cfg_mult16.sv
module cfg_mult16
    import cfgmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    input  logic [MODE_W-1:0] mode_in,
    output logic [PROD_W-1:0] prod_q
);

    mode_t             mode_raw;
    zinfo_t            zin;
    logic [WORD_W-1:0] a_q, b_q;
    mode_t             mode_q;
    logic              zero_q;
    logic              sign_q;

    assign mode_raw = mode_t'(mode_in);

    cfgmul_sbg u_sbg (
        .a     (a_in),
        .b     (b_in),
        .shape (mode_raw.shape),
        .info  (zin)
    );

    // Stage 1: operand registers, frozen on shutdown
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            mode_q <= '{shape: SHAPE_WIDE, full: 1'b1};
            zero_q <= 1'b1;
            sign_q <= 1'b0;
        end else if (zin.shut) begin
            zero_q <= 1'b1;
            sign_q <= 1'b0;
        end else begin
            a_q    <= a_in;
            b_q    <= b_in;
            mode_q <= mode_raw;
            zero_q <= 1'b0;
            sign_q <= zin.sign;
        end
    end

    // Sub-product array: index bit 1 picks the A byte, bit 0 the B byte
    logic signed [SUB_W-1:0] sub_p [N_SUB];
    logic                    wide_q;

    assign wide_q = is_wide(mode_q.shape);

    for (genvar i = 0; i < N_SUB; i++) begin : g_sub
        sub_op_t op;
        always_comb begin
            logic [HALF_W-1:0] ab, bb;
            ab    = (i[1]) ? a_q[WORD_W-1:HALF_W] : a_q[HALF_W-1:0];
            bb    = (i[0]) ? b_q[WORD_W-1:HALF_W] : b_q[HALF_W-1:0];
            op.x  = widen(ab, wide_q ? i[1] : 1'b1);
            op.y  = widen(bb, wide_q ? i[0] : 1'b1);
            op.en = wide_q || (i == 0) ||
                    ((i == N_SUB-1) && (mode_q.shape == SHAPE_TWIN));
        end
        cfgmul_sub u_sub (.op(op), .p(sub_p[i]));
    end

    // Combine and truncate
    logic signed [PROD_W-1:0] wide_sum;
    logic        [PROD_W-1:0] raw, keep;

    always_comb begin
        wide_sum = (PROD_W'(sub_p[3]) <<< WORD_W)
                 + (PROD_W'(sub_p[2]) <<< HALF_W)
                 + (PROD_W'(sub_p[1]) <<< HALF_W)
                 +  PROD_W'(sub_p[0]);
        keep = '1;
        if (wide_q) begin
            raw = wide_sum;
            if (!mode_q.full) keep[WORD_W-1:0] = '0;
        end else if (mode_q.shape == SHAPE_BYTE) begin
            raw = PROD_W'(sub_p[0]);
            if (!mode_q.full) keep[HALF_W-1:0] = '0;
        end else begin
            raw = {sub_p[3][WORD_W-1:0], sub_p[0][WORD_W-1:0]};
            if (!mode_q.full) begin
                keep[HALF_W-1:0]               = '0;
                keep[WORD_W+HALF_W-1:WORD_W]   = '0;
            end
        end
    end

    // Stage 2: product register
    always_ff @(posedge clk) begin
        if (rst)         prod_q <= '0;
        else if (zero_q) prod_q <= '0;
        else             prod_q <= raw & keep;
    end

    p_shut_hold_r8: assert property (@(posedge clk) disable iff (rst)
        zin.shut |=> zero_q);

    p_shut_clear_r8: assert property (@(posedge clk) disable iff (rst)
        zero_q |=> (prod_q == '0));

    p_sign_match_r3: assert property (@(posedge clk) disable iff (rst)
        !zero_q |=> (prod_q[PROD_W-1] == $past(sign_q)));

    p_unused_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !wide_q |-> (sub_p[1] == '0 && sub_p[2] == '0));

    p_trunc_low_r6: assert property (@(posedge clk) disable iff (rst)
        (!zero_q && !mode_q.full) |=> (prod_q[HALF_W-1:0] == '0));

endmodule

// File: tb/tb_cfg_mult16.sv
module tb_cfg_mult16;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] a_in, b_in;
    logic [2:0]  mode_in;
    logic [31:0] prod_q;

    int n_run  = 0;
    int n_fail = 0;

    cfg_mult16 dut (
        .clk     (clk),
        .rst     (rst),
        .a_in    (a_in),
        .b_in    (b_in),
        .mode_in (mode_in),
        .prod_q  (prod_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {mode, a, b, expected}
    localparam logic [66:0] VEC [NV] = '{
        {3'b111, 16'h0003, 16'h0005, 32'h0000000F},  // R3
        {3'b111, 16'hFFFF, 16'h0002, 32'hFFFFFFFE},  // R3
        {3'b111, 16'h0100, 16'h0100, 32'h00010000},  // R3
        {3'b111, 16'h8000, 16'h8000, 32'h40000000},  // R3
        {3'b111, 16'h00FF, 16'h00FF, 32'h0000FE01},  // R3 low bytes unsigned
        {3'b011, 16'hFFFF, 16'hFFFF, 32'h00000001},  // R7
        {3'b101, 16'h12FD, 16'h3404, 32'hFFFFFFF4},  // R4 R9
        {3'b001, 16'h0302, 16'hFF05, 32'hFFFD000A},  // R5 R9
        {3'b001, 16'h807F, 16'h807F, 32'h40003F01},  // R5
        {3'b110, 16'h0100, 16'h0101, 32'h00010000},  // R6 wide
        {3'b100, 16'h00FF, 16'h0003, 32'hFFFFFF00},  // R6 byte
        {3'b000, 16'h0210, 16'h0310, 32'h00000100},  // R6 twin
        {3'b001, 16'h0005, 16'h0707, 32'h00000023},  // R10
        {3'b111, 16'h0000, 16'h1234, 32'h00000000},  // R8 wide
        {3'b101, 16'h1200, 16'h0005, 32'h00000000}   // R8 byte
    };

    localparam string TAG [NV] = '{
        "R3", "R3", "R3", "R3", "R3", "R7", "R4/R9", "R5/R9", "R5",
        "R6", "R6", "R6", "R10", "R8", "R8"
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: prod_q=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] m, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        mode_in = m;
        a_in    = a;
        b_in    = b;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; a_in = '0; b_in = '0; mode_in = 3'b111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", prod_q, 32'h0);
        rst = 1'b0;

        // R2: latency of two edges
        a_in = 16'd3; b_in = 16'd5; mode_in = 3'b111;
        @(posedge clk); @(negedge clk);
        check("R2 held after one edge", prod_q, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R2 due after two edges", prod_q, 32'h0000000F);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][66:64], VEC[i][63:48], VEC[i][47:32]);
            check(TAG[i], prod_q, VEC[i][31:0]);
        end

        // R4 R9: high bytes changed, same low bytes -> same result
        apply(3'b101, 16'hA5FD, 16'h5A04);
        check("R4/R9 high bytes ignored", prod_q, 32'hFFFFFFF4);

        // R8: after shutdown, a valid operand pair computes normally again
        apply(3'b111, 16'h0000, 16'h0000);
        check("R8 both zero", prod_q, 32'h0);
        apply(3'b111, 16'h0007, 16'hFFFF);
        check("R8 recovery", prod_q, 32'hFFFFFFF9);

        // R8 twin: both lanes have a zero byte
        apply(3'b001, 16'h0500, 16'h0009);
        check("R8 twin shut", prod_q, 32'h0);

        // R1: reset clears a live result
        apply(3'b111, 16'h0010, 16'h0010);
        check("R3 pre-reset", prod_q, 32'h00000100);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 reset clears output", prod_q, 32'h0);
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule